// File: doc/BRIEF.md
# Transport Stream PID Splice Controller

This block swaps the elementary stream PIDs that a transport stream demultiplexer listens to. It does so at the packet boundary that the stream marks as the splice point. Each of two streams, audio and video, has an active PID and a standby PID. The active PID drives the PID filter. The standby PID, held in a host-writable splice control register together with an enable bit, is the PID to change to. An upstream header parser reports fields for each packet: the PID, whether an adaptation field is present, the splicing-point flag and the signed 8-bit splice countdown. A separate strobe marks the last byte of the packet.

When a packet on a stream's active PID carries the splicing-point indication with a countdown of zero, and splicing is enabled for that stream, the two PIDs change places at the end of that packet. That packet is still filtered under the old PID. The next packet is filtered under the new one. The old PID is left in the standby register for a later splice back. A status word reports the latest countdown seen on either active PID and three sticky event bits, which a host read clears.

Top module: `ts_splice_ctrl`

## Requirements
- R1: After reset the active audio and video PIDs equal their reset parameters. Both splice control registers read zero, with enable off, and the status word reads zero.
- R2: A host write updates one register, chosen by `host_sel`: 0 = active audio PID, 1 = audio splice control, 2 = active video PID, 3 = video splice control. In a splice control register, bits [12:0] are the standby PID and bit 13 is the enable. The new value is visible on the outputs one cycle after the write.
- R3: A header counts for a stream only when an adaptation field is present, the splicing-point flag is set and the PID equals that stream's active PID. Such a header loads its countdown into status bits [7:0] one cycle later. Other headers leave bits [7:0] unchanged.
- R4: If a counting header has countdown 0 and its stream's enable is 1, the strobe for the last byte of that packet triggers a swap. One cycle after the strobe, the active PID equals the previous standby PID and the standby field equals the previous active PID.
- R5: With enable 0, a counting header still loads the countdown into the status word, but no swap follows and no event bit is set.
- R6: The active PIDs do not change between a header and the end of its packet, unless the host writes them.
- R7: A countdown other than zero, positive or negative (0xFF is -1), never triggers a swap.
- R8: A swap sets status bit 15 (end of splice packet) one cycle after the end-of-packet strobe. It also sets bit 14 for an audio swap or bit 13 for a video swap.
- R9: A host read returns the current status word. Bits 15:13 are clear on the following cycle and bits [7:0] are kept. If an event arrives in the same cycle as the read, its bit stays set.
- R10: A host write to a splice control register in the same cycle as that stream's swap sets the standby field and enable from the write data. The active PID still takes the previous standby PID.
- R11: Audio and video swap independently. A swap on one stream leaves the other stream's PIDs and event bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | One-cycle strobe: header fields are valid |
| hdr_pid | input | 13 | PID of the packet |
| hdr_af_present | input | 1 | Adaptation field present |
| hdr_splice_point | input | 1 | Splicing-point flag in the adaptation field |
| hdr_countdown | input | 8 | Signed splice countdown |
| pkt_end | input | 1 | One-cycle strobe on the last byte of the packet |
| host_wr | input | 1 | Host register write strobe |
| host_sel | input | 2 | Register select for the write (see R2) |
| host_wdata | input | 14 | Write data: PID [12:0], enable [13] |
| host_rd | input | 1 | Host read strobe for the status word |
| active_audio_pid | output | 13 | Active audio PID to the filter |
| active_video_pid | output | 13 | Active video PID to the filter |
| audio_splice_cfg | output | 14 | Audio splice control register |
| video_splice_cfg | output | 14 | Video splice control register |
| splice_status | output | 16 | Event bits [15:13], countdown [7:0] |

## Verification
The countdown byte is due one cycle after the clock edge that takes the header. A swap and its event bits are due one cycle after the end-of-packet edge. Flags clear one cycle after the read edge, and host writes show one cycle after their edge. The driver sets each stimulus at a falling edge and updates its model just after the following rising edge, then queues the expected outputs. The monitor compares them at the next falling edge, so every comparison falls exactly in the cycle where the result is due. A read value is compared within the read cycle itself, before the clearing edge.

// File: rtl/ts_splice_pkg.sv
package ts_splice_pkg;
  localparam int PID_BITS = 13;
  localparam int CD_BITS  = 8;
  localparam int STAT_BITS = 16;

  typedef enum logic [1:0] {
    SEL_AUD_ACTIVE = 2'd0,
    SEL_AUD_SPLICE = 2'd1,
    SEL_VID_ACTIVE = 2'd2,
    SEL_VID_SPLICE = 2'd3
  } host_sel_e;

  // a header counts for a stream when it carries the splice marker on that stream's PID
  function automatic logic splice_hit(input logic af, input logic sp,
                                      input logic [PID_BITS-1:0] pid,
                                      input logic [PID_BITS-1:0] active);
    return af && sp && (pid == active);
  endfunction

  function automatic logic countdown_expired(input logic [CD_BITS-1:0] cd);
    return cd == '0;
  endfunction
endpackage

// File: rtl/splice_lane.sv
module splice_lane #(
  parameter int PID_W = ts_splice_pkg::PID_BITS,
  parameter logic [PID_W-1:0] RESET_PID = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hdr_valid,
  input  logic [PID_W-1:0] hdr_pid,
  input  logic             hdr_af,
  input  logic             hdr_sp,
  input  logic             hdr_cd_zero,
  input  logic             pkt_end,
  input  logic             wr_active,
  input  logic             wr_splice,
  input  logic [PID_W:0]   wr_data,
  output logic [PID_W-1:0] active_pid,
  output logic [PID_W:0]   splice_cfg,
  output logic             hit,
  output logic             swap_fire
);
  logic pending;
  logic enable;
  logic arm;

  assign enable    = splice_cfg[PID_W];
  assign hit       = hdr_valid && ts_splice_pkg::splice_hit(hdr_af, hdr_sp, hdr_pid, active_pid);
  assign arm       = hit && hdr_cd_zero && enable;
  assign swap_fire = pkt_end && pending && enable;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
    end else if (arm) begin
      pending <= 1'b1;
    end else if (pkt_end) begin
      pending <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_pid <= RESET_PID;
    end else if (wr_active) begin
      active_pid <= wr_data[PID_W-1:0];
    end else if (swap_fire) begin
      active_pid <= splice_cfg[PID_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      splice_cfg <= '0;
    end else if (wr_splice) begin
      splice_cfg <= wr_data;
    end else if (swap_fire) begin
      splice_cfg[PID_W-1:0] <= active_pid;
    end
  end

  a_r4_swap_exchange: assert property (@(posedge clk) disable iff (!rst_n)
    swap_fire && !wr_active && !wr_splice |=>
      active_pid == $past(splice_cfg[PID_W-1:0]) && splice_cfg[PID_W-1:0] == $past(active_pid));

  a_r10_host_wins_standby: assert property (@(posedge clk) disable iff (!rst_n)
    swap_fire && wr_splice && !wr_active |=>
      active_pid == $past(splice_cfg[PID_W-1:0]) && splice_cfg == $past(wr_data));

  a_r6_hold_mid_packet: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_end && !wr_active |=> $stable(active_pid));

  a_r5_disabled_no_swap: assert property (@(posedge clk) disable iff (!rst_n)
    !enable && !wr_active |=> $stable(active_pid));
endmodule

// File: rtl/splice_status.sv
module splice_status #(
  parameter int CD_W   = ts_splice_pkg::CD_BITS,
  parameter int STAT_W = ts_splice_pkg::STAT_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_any,
  input  logic [CD_W-1:0]   hdr_cd,
  input  logic              swap_aud,
  input  logic              swap_vid,
  input  logic              host_rd,
  output logic [STAT_W-1:0] status
);
  localparam int PAD_W = STAT_W - 3 - CD_W;

  logic [CD_W-1:0] cd_q;
  logic eosp_q, aud_q, vid_q;
  logic swap_any;

  assign swap_any = swap_aud || swap_vid;
  assign status   = {eosp_q, aud_q, vid_q, {PAD_W{1'b0}}, cd_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cd_q <= '0;
    end else if (hit_any) begin
      cd_q <= hdr_cd;
    end
  end

  // a new event outranks the read clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eosp_q <= 1'b0;
      aud_q  <= 1'b0;
      vid_q  <= 1'b0;
    end else begin
      if (swap_any)     eosp_q <= 1'b1;
      else if (host_rd) eosp_q <= 1'b0;
      if (swap_aud)     aud_q  <= 1'b1;
      else if (host_rd) aud_q  <= 1'b0;
      if (swap_vid)     vid_q  <= 1'b1;
      else if (host_rd) vid_q  <= 1'b0;
    end
  end

  a_r3_capture_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any |=> status[CD_W-1:0] == $past(hdr_cd));

  a_r8_audio_event: assert property (@(posedge clk) disable iff (!rst_n)
    swap_aud |=> status[STAT_W-1] && status[STAT_W-2]);

  a_r8_video_event: assert property (@(posedge clk) disable iff (!rst_n)
    swap_vid |=> status[STAT_W-1] && status[STAT_W-3]);

  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && !swap_any |=> status[STAT_W-1:STAT_W-3] == 3'b000 && $stable(status[CD_W-1:0]));

  initial begin
    a_r9_layout_fits: assert (PAD_W >= 0);
  end
endmodule

// File: rtl/ts_splice_ctrl.sv
module ts_splice_ctrl #(
  parameter int PID_W  = ts_splice_pkg::PID_BITS,
  parameter int CD_W   = ts_splice_pkg::CD_BITS,
  parameter int STAT_W = ts_splice_pkg::STAT_BITS,
  parameter logic [PID_W-1:0] RESET_AUDIO_PID = 13'h0100,
  parameter logic [PID_W-1:0] RESET_VIDEO_PID = 13'h0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_valid,
  input  logic [PID_W-1:0]  hdr_pid,
  input  logic              hdr_af_present,
  input  logic              hdr_splice_point,
  input  logic [CD_W-1:0]   hdr_countdown,
  input  logic              pkt_end,
  input  logic              host_wr,
  input  logic [1:0]        host_sel,
  input  logic [PID_W:0]    host_wdata,
  input  logic              host_rd,
  output logic [PID_W-1:0]  active_audio_pid,
  output logic [PID_W-1:0]  active_video_pid,
  output logic [PID_W:0]    audio_splice_cfg,
  output logic [PID_W:0]    video_splice_cfg,
  output logic [STAT_W-1:0] splice_status
);
  import ts_splice_pkg::*;

  localparam int LANES = 2; // 0 = audio, 1 = video

  logic             cd_zero;
  logic [LANES-1:0] lane_hit;
  logic [LANES-1:0] lane_swap;
  logic [PID_W-1:0] lane_active [LANES];
  logic [PID_W:0]   lane_cfg    [LANES];

  assign cd_zero = countdown_expired(hdr_countdown);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic wr_act, wr_spl;
    assign wr_act = host_wr && (host_sel == ((g == 0) ? SEL_AUD_ACTIVE : SEL_VID_ACTIVE));
    assign wr_spl = host_wr && (host_sel == ((g == 0) ? SEL_AUD_SPLICE : SEL_VID_SPLICE));

    splice_lane #(
      .PID_W     (PID_W),
      .RESET_PID ((g == 0) ? RESET_AUDIO_PID : RESET_VIDEO_PID)
    ) u_lane (
      .clk         (clk),
      .rst_n       (rst_n),
      .hdr_valid   (hdr_valid),
      .hdr_pid     (hdr_pid),
      .hdr_af      (hdr_af_present),
      .hdr_sp      (hdr_splice_point),
      .hdr_cd_zero (cd_zero),
      .pkt_end     (pkt_end),
      .wr_active   (wr_act),
      .wr_splice   (wr_spl),
      .wr_data     (host_wdata),
      .active_pid  (lane_active[g]),
      .splice_cfg  (lane_cfg[g]),
      .hit         (lane_hit[g]),
      .swap_fire   (lane_swap[g])
    );
  end

  splice_status #(.CD_W(CD_W), .STAT_W(STAT_W)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_any  (|lane_hit),
    .hdr_cd   (hdr_countdown),
    .swap_aud (lane_swap[0]),
    .swap_vid (lane_swap[1]),
    .host_rd  (host_rd),
    .status   (splice_status)
  );

  assign active_audio_pid = lane_active[0];
  assign active_video_pid = lane_active[1];
  assign audio_splice_cfg = lane_cfg[0];
  assign video_splice_cfg = lane_cfg[1];

  a_r11_audio_swap_spares_video: assert property (@(posedge clk) disable iff (!rst_n)
    lane_swap[0] && !lane_swap[1] && !host_wr |=>
      $stable(active_video_pid) && $stable(video_splice_cfg));
endmodule

// File: tb/ts_splice_ctrl_bench.sv
module ts_splice_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hdr_valid = 1'b0;
  logic [12:0] hdr_pid = '0;
  logic        hdr_af_present = 1'b0;
  logic        hdr_splice_point = 1'b0;
  logic [7:0]  hdr_countdown = '0;
  logic        pkt_end = 1'b0;
  logic        host_wr = 1'b0;
  logic [1:0]  host_sel = '0;
  logic [13:0] host_wdata = '0;
  logic        host_rd = 1'b0;
  logic [12:0] active_audio_pid, active_video_pid;
  logic [13:0] audio_splice_cfg, video_splice_cfg;
  logic [15:0] splice_status;

  always #10 clk = ~clk;

  ts_splice_ctrl u_ts_splice_ctrl (.*);

  typedef struct {
    string       req;
    logic [12:0] aa, va;
    logic [13:0] ac, vc;
    logic [15:0] st;
  } exp_t;

  exp_t sb[$];
  int vectors = 0;
  int misses  = 0;

  // reference state, kept from the requirements
  logic [12:0] m_aa = 13'h0100, m_va = 13'h0101;
  logic [13:0] m_ac = '0, m_vc = '0;
  logic [7:0]  m_cd = '0;
  logic        m_eo = 0, m_af = 0, m_vf = 0;
  logic        m_pa = 0, m_pv = 0;

  function automatic logic [15:0] m_status();
    return {m_eo, m_af, m_vf, 5'b0, m_cd};
  endfunction

  function automatic void check(string req, string what, logic [15:0] got, logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endfunction

  task automatic push(string req);
    exp_t e;
    e.req = req; e.aa = m_aa; e.va = m_va; e.ac = m_ac; e.vc = m_vc; e.st = m_status();
    sb.push_back(e);
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(e.req, "active audio", 16'(active_audio_pid), 16'(e.aa));
      check(e.req, "active video", 16'(active_video_pid), 16'(e.va));
      check(e.req, "audio cfg", 16'(audio_splice_cfg), 16'(e.ac));
      check(e.req, "video cfg", 16'(video_splice_cfg), 16'(e.vc));
      check(e.req, "status", splice_status, e.st);
    end
  end

  task automatic host_write(logic [1:0] sel, logic [13:0] d, string req);
    @(negedge clk);
    host_wr = 1; host_sel = sel; host_wdata = d;
    @(posedge clk); #1;
    host_wr = 0;
    case (sel)
      2'd0: m_aa = d[12:0];
      2'd1: m_ac = d;
      2'd2: m_va = d[12:0];
      default: m_vc = d;
    endcase
    push(req);
  endtask

  // header cycle, one mid-packet cycle, end-of-packet cycle (optional host write there)
  task automatic packet(logic [12:0] pid, logic af, logic sp, logic [7:0] cd,
                        logic wr_at_end, logic [1:0] sel, logic [13:0] d, string req);
    logic ha, hv, fa, fv;
    logic [12:0] oaa, ova;
    logic [13:0] oac, ovc;
    @(negedge clk);
    hdr_valid = 1; hdr_pid = pid; hdr_af_present = af; hdr_splice_point = sp; hdr_countdown = cd;
    @(posedge clk); #1;
    hdr_valid = 0;
    ha = af && sp && pid == m_aa;
    hv = af && sp && pid == m_va;
    if (ha || hv) m_cd = cd;
    m_pa = ha && cd == 0 && m_ac[13];
    m_pv = hv && cd == 0 && m_vc[13];
    push({req, "/R6 header"});
    @(negedge clk);
    @(posedge clk); #1;
    push({req, "/R6 mid"});
    @(negedge clk);
    pkt_end = 1;
    if (wr_at_end) begin host_wr = 1; host_sel = sel; host_wdata = d; end
    @(posedge clk); #1;
    pkt_end = 0; host_wr = 0;
    fa = m_pa && m_ac[13];
    fv = m_pv && m_vc[13];
    oaa = m_aa; ova = m_va; oac = m_ac; ovc = m_vc;
    if (fa) begin m_aa = oac[12:0]; m_ac[12:0] = oaa; end
    if (fv) begin m_va = ovc[12:0]; m_vc[12:0] = ova; end
    if (wr_at_end) begin
      case (sel)
        2'd0: m_aa = d[12:0];
        2'd1: m_ac = d;
        2'd2: m_va = d[12:0];
        default: m_vc = d;
      endcase
    end
    if (fa || fv) m_eo = 1;
    if (fa) m_af = 1;
    if (fv) m_vf = 1;
    m_pa = 0; m_pv = 0;
    push({req, " end"});
  endtask

  task automatic read_status(string req);
    @(negedge clk);
    host_rd = 1;
    #1 check(req, "read value", splice_status, m_status());
    @(posedge clk); #1;
    host_rd = 0;
    m_eo = 0; m_af = 0; m_vf = 0;
    push(req);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    push("R1 reset");
    host_write(2'd1, 14'h2200, "R2 audio splice write");
    host_write(2'd3, 14'h0300, "R2 video splice write, disabled");
    packet(13'h0100, 1, 1, 8'd3,   0, 0, 0, "R3 R7 countdown 3");
    packet(13'h0100, 0, 1, 8'd5,   0, 0, 0, "R3 no adaptation field");
    packet(13'h0155, 1, 1, 8'd0,   0, 0, 0, "R3 foreign PID");
    packet(13'h0100, 1, 1, 8'hFF,  0, 0, 0, "R7 negative countdown");
    packet(13'h0100, 1, 1, 8'd0,   0, 0, 0, "R4 R8 audio swap");
    read_status("R9 read clears");
    packet(13'h0101, 1, 1, 8'd0,   0, 0, 0, "R5 video disabled");
    host_write(2'd3, 14'h2300, "R2 video enable");
    packet(13'h0101, 1, 1, 8'd0,   0, 0, 0, "R11 video swap only");
    packet(13'h0200, 1, 1, 8'd0,   1, 2'd1, 14'h2055, "R10 write during swap");
    read_status("R9 read after two swaps");
    host_write(2'd0, 14'h00AB, "R2 active audio write");
    packet(13'h0100, 1, 1, 8'd0,   0, 0, 0, "R3 old audio PID no longer active");
    repeat (3) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule